// File: doc/BRIEF.md
# Configurable-Width Dual-Clock FIFO

This block is a first-in first-out buffer whose write side and read side run on separate clocks. The two clocks may be unrelated or may come from one source. A three-bit shape code on each side picks the word shape at run time: 4096 words of 1 bit, 2048 of 2, 1024 of 4, 512 of 9 or 256 of 18. Both data buses are 18 bits wide. Narrower shapes use only the low-order lanes.

Each side has an active-low port enable and a data enable. The polarity of each data enable is a parameter. A run-time select chooses between an unregistered read output and one with an extra output register. The write side reports full, almost-full and a one-cycle overflow pulse. The read side reports empty, almost-empty and a one-cycle underflow pulse.

Pointers cross between the two domains as Gray code through a synchroniser chain. As a result, full and empty can report late but never early. All storage sits in one 256-row by 18-bit array with per-bit write enables.

Top module: `ar_fifo`

## Requirements
- R1: The shape code sets the capacity: 000 holds 4096 words, 001 holds 2048, 010 holds 1024, 011 holds 512 and 100 holds 256. Full asserts once exactly that many words have been written with no reads.
- R2: The word width is 1, 2, 4, 9 or 18 bits for codes 000 to 100, carried on bits [N-1:0]. Write bits above N are ignored, and read bits above N read as zero.
- R3: The port enables are active low. While the write-port enable is high, no word is stored. While the read-port enable is high, no word is consumed and the read data output keeps its value.
- R4: With default parameters the write data enable is active low and the read data enable is active high. A parameter per side inverts each one. An inactive data enable stores or consumes nothing.
- R5: With the pipeline select low, the word consumed at a read-clock edge appears on the read data output after that same edge.
- R6: With the pipeline select high, the consumed word appears one read-clock edge later. Until then the output still shows the earlier value.
- R7: While the active-low reset is held across clock edges, both pointers clear, read data goes to zero, full and almost-full go low, and empty and almost-empty go high.
- R8: A write while full and a read while empty leave the contents and pointers unchanged. Each raises a pulse on its own side (overflow or underflow) for exactly one cycle of that side's clock.
- R9: Almost-full is high when the fill level seen by the write side is at least AFULL_LVL words. Almost-empty is high when the level seen by the read side is at most AEMPTY_LVL words.
- R10: If the two shape codes differ, or either one is 101, 110 or 111, the block is held in reset. No word is stored, empty stays high and full stays low.
- R11: Words leave in the order they were written, bit-exact within their width. This holds for equal and for unequal write and read clock periods.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_n | input | 1 | Active-low reset, sampled on each side's clock |
| wr_clk | input | 1 | Write clock |
| wr_shape | input | 3 | Write-side shape code |
| wr_blk_n | input | 1 | Write-port enable, active low |
| wr_en | input | 1 | Write data enable, polarity set by WEN_HIGH |
| wr_data | input | 18 | Write word, low lanes used |
| wr_full | output | 1 | No room for another word |
| wr_afull | output | 1 | Level at or above AFULL_LVL |
| wr_ovf | output | 1 | One-cycle pulse on a refused write |
| rd_clk | input | 1 | Read clock |
| rd_shape | input | 3 | Read-side shape code |
| rd_blk_n | input | 1 | Read-port enable, active low |
| rd_en | input | 1 | Read data enable, polarity set by REN_HIGH |
| rd_pipe_sel | input | 1 | 1 adds an output register stage |
| rd_data | output | 18 | Read word, upper lanes zero |
| rd_empty | output | 1 | No word available |
| rd_aempty | output | 1 | Level at or below AEMPTY_LVL |
| rd_udf | output | 1 | One-cycle pulse on a refused read |

## Verification
The hardest states to reach are the exact capacity boundary in the deepest shape and the threshold edges, because each flag settles only after the opposite pointer has crossed the synchroniser. The bench fills every shape to exactly its capacity. It pauses at the word counts on either side of both thresholds, waiting long enough for both domains to settle before sampling the flags. It then forces one refused write at full and one refused read at empty. Refused and blocked reads are confirmed through the read stream itself: the next word read must still be the next one in sequence.

// File: rtl/arf_pkg.sv
package arf_pkg;
  localparam int DATA_W = 18;
  localparam int ROW_AW = 8;
  localparam int ROWS   = 1 << ROW_AW;
  localparam int PTR_W  = 13;   // 4096 words plus wrap bit
  localparam int POS_W  = 5;

  localparam logic [2:0] SH_X1  = 3'd0;
  localparam logic [2:0] SH_X2  = 3'd1;
  localparam logic [2:0] SH_X4  = 3'd2;
  localparam logic [2:0] SH_X9  = 3'd3;
  localparam logic [2:0] SH_X18 = 3'd4;

  function automatic logic shape_ok(input logic [2:0] c);
    return c <= SH_X18;
  endfunction

  function automatic logic [PTR_W-1:0] depth_of(input logic [2:0] c);
    case (c)
      SH_X1:   return PTR_W'(4096);
      SH_X2:   return PTR_W'(2048);
      SH_X4:   return PTR_W'(1024);
      SH_X9:   return PTR_W'(512);
      default: return PTR_W'(256);
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] lane_mask(input logic [2:0] c);
    case (c)
      SH_X1:   return DATA_W'(18'h00001);
      SH_X2:   return DATA_W'(18'h00003);
      SH_X4:   return DATA_W'(18'h0000F);
      SH_X9:   return DATA_W'(18'h001FF);
      default: return DATA_W'(18'h3FFFF);
    endcase
  endfunction

  // row of the shared array that holds word p
  function automatic logic [ROW_AW-1:0] row_of(input logic [2:0] c, input logic [PTR_W-1:0] p);
    case (c)
      SH_X1:   return p[11:4];
      SH_X2:   return p[10:3];
      SH_X4:   return p[9:2];
      SH_X9:   return p[8:1];
      default: return p[7:0];
    endcase
  endfunction

  // lowest bit of word p inside its row
  function automatic logic [POS_W-1:0] pos_of(input logic [2:0] c, input logic [PTR_W-1:0] p);
    case (c)
      SH_X1:   return {1'b0, p[3:0]};
      SH_X2:   return {1'b0, p[2:0], 1'b0};
      SH_X4:   return {1'b0, p[1:0], 2'b00};
      SH_X9:   return p[0] ? 5'd9 : 5'd0;
      default: return 5'd0;
    endcase
  endfunction

  function automatic logic [PTR_W-1:0] bin2gray(input logic [PTR_W-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PTR_W-1:0] gray2bin(input logic [PTR_W-1:0] g);
    logic [PTR_W-1:0] b;
    b[PTR_W-1] = g[PTR_W-1];
    for (int i = PTR_W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction
endpackage

// File: rtl/arf_sync.sv
module arf_sync #(
  parameter int W      = 13,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stg
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stg[i] <= '0;
        else     stg[i] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stg[i] <= '0;
        else     stg[i] <= stg[i-1];
      end
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/arf_mem.sv
module arf_mem #(
  parameter int W  = 18,
  parameter int AW = 8
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] wrow,
  input  logic [W-1:0]  wmask,
  input  logic [W-1:0]  wbits,
  input  logic          rclk,
  input  logic          rrst,
  input  logic          re,
  input  logic [AW-1:0] rrow,
  output logic [W-1:0]  rword
);
  localparam int NROWS = 1 << AW;
  logic [W-1:0] cells [NROWS];

  always_ff @(posedge wclk) begin
    if (we) begin
      for (int i = 0; i < W; i++) begin
        if (wmask[i]) cells[wrow][i] <= wbits[i];
      end
    end
  end

  always_ff @(posedge rclk) begin
    if (rrst)    rword <= '0;
    else if (re) rword <= cells[rrow];
  end
endmodule

// File: rtl/arf_wr_side.sv
module arf_wr_side import arf_pkg::*; #(
  parameter int AFULL_LVL = 192,
  parameter bit WEN_HIGH  = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        shape,
  input  logic              blk_n,
  input  logic              en,
  input  logic [DATA_W-1:0] data,
  input  logic [PTR_W-1:0]  rgray_s,
  output logic              full,
  output logic              afull,
  output logic              ovf,
  output logic [PTR_W-1:0]  wgray,
  output logic              mem_we,
  output logic [ROW_AW-1:0] mem_row,
  output logic [DATA_W-1:0] mem_mask,
  output logic [DATA_W-1:0] mem_bits
);
  localparam logic [PTR_W-1:0] AF_L = PTR_W'(AFULL_LVL);

  logic              en_act, req, accept;
  logic [PTR_W-1:0]  wbin, wnext, rbin_s, lvl_next, depth;
  logic [DATA_W-1:0] lane;
  logic [POS_W-1:0]  pos;

  assign en_act   = WEN_HIGH ? en : ~en;
  assign req      = ~blk_n & en_act;
  assign accept   = req & ~full;
  assign wnext    = wbin + PTR_W'(accept);
  assign rbin_s   = gray2bin(rgray_s);
  assign lvl_next = wnext - rbin_s;
  assign depth    = depth_of(shape);

  assign lane     = lane_mask(shape);
  assign pos      = pos_of(shape, wbin);
  assign mem_we   = accept;
  assign mem_row  = row_of(shape, wbin);
  assign mem_mask = lane << pos;
  assign mem_bits = (data & lane) << pos;

  always_ff @(posedge clk) begin
    if (rst) begin
      wbin  <= '0;
      wgray <= '0;
      full  <= 1'b0;
      afull <= 1'b0;
      ovf   <= 1'b0;
    end else begin
      wbin  <= wnext;
      wgray <= bin2gray(wnext);
      full  <= (lvl_next == depth);
      afull <= (lvl_next >= AF_L);
      ovf   <= req & full;
    end
  end

  // R7: reset leaves the write flags low
  a_r7_wr_reset_flags: assert property (@(posedge clk) rst |=> (!full && !afull && !ovf));
  // R8: refused write keeps the pointer and pulses overflow
  a_r8_full_blocks: assert property (@(posedge clk) disable iff (rst)
    (full && req) |=> ($stable(wbin) && ovf));
  // R8: overflow pulse lasts one cycle without a new attempt
  a_r8_ovf_single: assert property (@(posedge clk) disable iff (rst)
    (ovf && !$past(req)) |-> 1'b0 || !ovf);
  // R1: the level seen by the write side never exceeds the capacity
  a_r1_level_bound: assert property (@(posedge clk) disable iff (rst)
    (wbin - rbin_s) <= depth);
endmodule

// File: rtl/arf_rd_side.sv
module arf_rd_side import arf_pkg::*; #(
  parameter int AEMPTY_LVL = 4,
  parameter bit REN_HIGH   = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        shape,
  input  logic              blk_n,
  input  logic              en,
  input  logic              pipe_sel,
  input  logic [PTR_W-1:0]  wgray_s,
  input  logic [DATA_W-1:0] mem_rword,
  output logic              mem_re,
  output logic [ROW_AW-1:0] mem_row,
  output logic [DATA_W-1:0] data,
  output logic              empty,
  output logic              aempty,
  output logic              udf,
  output logic [PTR_W-1:0]  rgray
);
  localparam logic [PTR_W-1:0] AE_L = PTR_W'(AEMPTY_LVL);

  logic              en_act, req, accept;
  logic [PTR_W-1:0]  rbin, rnext, wbin_s, lvl_next;
  logic [POS_W-1:0]  rsel;
  logic [DATA_W-1:0] stage0, pipe_q;

  assign en_act   = REN_HIGH ? en : ~en;
  assign req      = ~blk_n & en_act;
  assign accept   = req & ~empty;
  assign rnext    = rbin + PTR_W'(accept);
  assign wbin_s   = gray2bin(wgray_s);
  assign lvl_next = wbin_s - rnext;

  assign mem_re   = accept;
  assign mem_row  = row_of(shape, rbin);
  assign stage0   = (mem_rword >> rsel) & lane_mask(shape);
  assign data     = pipe_sel ? pipe_q : stage0;

  always_ff @(posedge clk) begin
    if (rst) begin
      rbin   <= '0;
      rgray  <= '0;
      empty  <= 1'b1;
      aempty <= 1'b1;
      udf    <= 1'b0;
      rsel   <= '0;
      pipe_q <= '0;
    end else begin
      rbin   <= rnext;
      rgray  <= bin2gray(rnext);
      empty  <= (lvl_next == '0);
      aempty <= (lvl_next <= AE_L);
      udf    <= req & empty;
      if (accept) rsel   <= pos_of(shape, rbin);
      if (!blk_n) pipe_q <= stage0;
    end
  end

  // R7: reset empties the read side and zeroes the output
  a_r7_rd_reset_flags: assert property (@(posedge clk) rst |=> (empty && aempty && data == '0));
  // R8: refused read keeps the pointer and pulses underflow
  a_r8_empty_blocks: assert property (@(posedge clk) disable iff (rst)
    (empty && req) |=> ($stable(rbin) && udf));
  // R3: a disabled read port holds its output
  a_r3_hold_output: assert property (@(posedge clk) disable iff (rst)
    (blk_n && $stable(pipe_sel)) |=> $stable(data));
  // R3: a disabled read port consumes nothing
  a_r3_no_consume: assert property (@(posedge clk) disable iff (rst)
    blk_n |=> $stable(rbin));
endmodule

// File: rtl/ar_fifo.sv
module ar_fifo import arf_pkg::*; #(
  parameter int AFULL_LVL   = 192,
  parameter int AEMPTY_LVL  = 4,
  parameter bit WEN_HIGH    = 1'b0,
  parameter bit REN_HIGH    = 1'b1,
  parameter int SYNC_STAGES = 2
) (
  input  logic        rst_n,
  input  logic        wr_clk,
  input  logic [2:0]  wr_shape,
  input  logic        wr_blk_n,
  input  logic        wr_en,
  input  logic [17:0] wr_data,
  output logic        wr_full,
  output logic        wr_afull,
  output logic        wr_ovf,
  input  logic        rd_clk,
  input  logic [2:0]  rd_shape,
  input  logic        rd_blk_n,
  input  logic        rd_en,
  input  logic        rd_pipe_sel,
  output logic [17:0] rd_data,
  output logic        rd_empty,
  output logic        rd_aempty,
  output logic        rd_udf
);
  logic              cfg_bad, wrst, rrst;
  logic [PTR_W-1:0]  wgray, rgray, wgray_s, rgray_s;
  logic              mem_we, mem_re;
  logic [ROW_AW-1:0] wrow, rrow;
  logic [DATA_W-1:0] wmask, wbits, rword;

  // shape codes are static configuration; a bad pair holds both sides in reset
  assign cfg_bad = (wr_shape != rd_shape) | ~shape_ok(wr_shape);
  assign wrst    = ~rst_n | cfg_bad;
  assign rrst    = ~rst_n | cfg_bad;

  arf_wr_side #(.AFULL_LVL(AFULL_LVL), .WEN_HIGH(WEN_HIGH)) u_wr (
    .clk(wr_clk), .rst(wrst), .shape(wr_shape), .blk_n(wr_blk_n), .en(wr_en),
    .data(wr_data), .rgray_s(rgray_s), .full(wr_full), .afull(wr_afull),
    .ovf(wr_ovf), .wgray(wgray), .mem_we(mem_we), .mem_row(wrow),
    .mem_mask(wmask), .mem_bits(wbits)
  );

  arf_rd_side #(.AEMPTY_LVL(AEMPTY_LVL), .REN_HIGH(REN_HIGH)) u_rd (
    .clk(rd_clk), .rst(rrst), .shape(rd_shape), .blk_n(rd_blk_n), .en(rd_en),
    .pipe_sel(rd_pipe_sel), .wgray_s(wgray_s), .mem_rword(rword),
    .mem_re(mem_re), .mem_row(rrow), .data(rd_data), .empty(rd_empty),
    .aempty(rd_aempty), .udf(rd_udf), .rgray(rgray)
  );

  arf_sync #(.W(PTR_W), .STAGES(SYNC_STAGES)) u_w2r (
    .clk(rd_clk), .rst(rrst), .d(wgray), .q(wgray_s)
  );

  arf_sync #(.W(PTR_W), .STAGES(SYNC_STAGES)) u_r2w (
    .clk(wr_clk), .rst(wrst), .d(rgray), .q(rgray_s)
  );

  arf_mem #(.W(DATA_W), .AW(ROW_AW)) u_mem (
    .wclk(wr_clk), .we(mem_we), .wrow(wrow), .wmask(wmask), .wbits(wbits),
    .rclk(rd_clk), .rrst(rrst), .re(mem_re), .rrow(rrow), .rword(rword)
  );

  // R10: a bad shape pair keeps the write side from reporting full
  a_r10_bad_cfg_wr: assert property (@(posedge wr_clk) disable iff (!rst_n)
    cfg_bad |=> (!wr_full && !wr_afull));
  // R10: a bad shape pair keeps the read side empty
  a_r10_bad_cfg_rd: assert property (@(posedge rd_clk) disable iff (!rst_n)
    cfg_bad |=> (rd_empty && rd_aempty));
  // R2: lanes above the selected width read as zero
  a_r2_upper_zero: assert property (@(posedge rd_clk) disable iff (rrst)
    (rd_data & ~lane_mask(rd_shape)) == '0);
endmodule

// File: tb/ar_fifo_bench.sv
module ar_fifo_bench;
  localparam int AF = 200;
  localparam int AE = 3;

  logic wclk = 1'b0;
  logic rclk = 1'b0;
  int   rhalf = 4;
  always #4 wclk = ~wclk;
  always #(rhalf) rclk = ~rclk;

  logic        rst_n = 1'b0;
  logic [2:0]  wsh = 3'd0, rsh = 3'd0;
  logic        wblk = 1'b1, wen = 1'b1, rblk = 1'b1, ren = 1'b0, pipe = 1'b0;
  logic [17:0] wdat = '0;
  logic        wr_full, wr_afull, wr_ovf, rd_empty, rd_aempty, rd_udf;
  logic [17:0] rd_data;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  ar_fifo #(.AFULL_LVL(AF), .AEMPTY_LVL(AE)) u_ar_fifo (
    .rst_n(rst_n), .wr_clk(wclk), .wr_shape(wsh), .wr_blk_n(wblk), .wr_en(wen),
    .wr_data(wdat), .wr_full(wr_full), .wr_afull(wr_afull), .wr_ovf(wr_ovf),
    .rd_clk(rclk), .rd_shape(rsh), .rd_blk_n(rblk), .rd_en(ren),
    .rd_pipe_sel(pipe), .rd_data(rd_data), .rd_empty(rd_empty),
    .rd_aempty(rd_aempty), .rd_udf(rd_udf)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [17:0] mask_of(input int s);
    case (s)
      0: return 18'h00001;
      1: return 18'h00003;
      2: return 18'h0000F;
      3: return 18'h001FF;
      default: return 18'h3FFFF;
    endcase
  endfunction

  function automatic logic [17:0] pat(input int n, input int s, input int r);
    return 18'(n * 37 + s * 5 + r * 11 + 1) & mask_of(s);
  endfunction

  task automatic wait_both(input int n);
    repeat (n) @(negedge wclk);
    repeat (n) @(negedge rclk);
  endtask

  task automatic do_reset(input logic [2:0] ws, input logic [2:0] rs);
    @(negedge wclk);
    wsh = ws; rsh = rs; rst_n = 1'b0;
    wblk = 1'b1; wen = 1'b1; rblk = 1'b1; ren = 1'b0;
    wait_both(3);
    rst_n = 1'b1;
    wait_both(2);
  endtask

  task automatic try_writes(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge wclk);
      wblk = 1'b0; wen = 1'b0; wdat = 18'(i + 1);
    end
    @(negedge wclk);
    wen = 1'b1; wblk = 1'b1;
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #1500000;
    if (!done) begin
      total++; bad++;
      $display("FAIL R11 watchdog actual=hung expected=finished");
      finish_run();
    end
  end

  initial begin
    for (int r = 0; r < 2; r++) begin
      rhalf = (r == 0) ? 4 : 7;
      pipe  = (r == 1);
      for (int s = 0; s < 5; s++) begin
        int          depth;
        logic [17:0] m, held, last;
        depth = 4096 >> s;
        m     = mask_of(s);
        do_reset(3'(s), 3'(s));
        // R7 reset values
        chk("R7 full", 32'(wr_full), 0);
        chk("R7 afull", 32'(wr_afull), 0);
        chk("R7 empty", 32'(rd_empty), 1);
        chk("R7 aempty", 32'(rd_aempty), 1);
        chk("R7 data", 32'(rd_data), 0);

        if (r == 0 && s == 0) begin
          // R3: write port disabled, data enable active
          for (int i = 0; i < 4; i++) begin
            @(negedge wclk); wblk = 1'b1; wen = 1'b0;
          end
          // R4: port enabled, write data enable inactive (high)
          for (int i = 0; i < 4; i++) begin
            @(negedge wclk); wblk = 1'b0; wen = 1'b1;
          end
          @(negedge wclk); wblk = 1'b1;
          // R4: read side with read enable inactive (low)
          rblk = 1'b0; ren = 1'b0;
          wait_both(8);
          chk("R3 R4 nothing stored", 32'(rd_empty), 1);
          rblk = 1'b1;
          // R10: mismatched codes
          do_reset(3'd1, 3'd2);
          try_writes(6);
          wait_both(8);
          chk("R10 mismatch empty", 32'(rd_empty), 1);
          chk("R10 mismatch full", 32'(wr_full), 0);
          // R10: reserved code
          do_reset(3'd5, 3'd5);
          try_writes(6);
          wait_both(8);
          chk("R10 reserved empty", 32'(rd_empty), 1);
          chk("R10 reserved aempty", 32'(rd_aempty), 1);
          do_reset(3'(s), 3'(s));
        end

        // fill to capacity, junk on unused upper lanes
        for (int n = 0; n < depth; n++) begin
          @(negedge wclk);
          wblk = 1'b0; wen = 1'b0;
          wdat = pat(n, s, r) | (~m & 18'h2D2D2);
          if (r == 0 && (n + 1 == AE || n + 1 == AE + 1 || n + 1 == AF - 1 || n + 1 == AF)) begin
            @(negedge wclk);
            wen = 1'b1;
            wait_both(8);
            chk("R9 aempty", 32'(rd_aempty), 32'(n + 1 <= AE));
            chk("R9 afull", 32'(wr_afull), 32'(n + 1 >= AF));
          end
        end
        @(negedge wclk);
        wen = 1'b1;
        wait_both(8);
        chk("R1 full at capacity", 32'(wr_full), 1);
        chk("R9 afull at capacity", 32'(wr_afull), 1);
        chk("R1 not empty", 32'(rd_empty), 0);

        // R8 refused write
        @(negedge wclk); wen = 1'b0; wdat = 18'h3FFFF;
        @(negedge wclk);
        chk("R8 overflow pulse", 32'(wr_ovf), 1);
        wen = 1'b1;
        @(negedge wclk);
        chk("R8 overflow one cycle", 32'(wr_ovf), 0);
        wblk = 1'b1;

        // drain
        rblk = 1'b0;
        last = '0;
        for (int n = 0; n < depth; n++) begin
          @(negedge rclk); ren = 1'b1;
          @(negedge rclk); ren = 1'b0;
          if (pipe) begin
            if (n == 0 && pat(0, s, r) != 0) chk("R6 not yet visible", 32'(rd_data), 0);
            @(negedge rclk);
            chk("R6 R2 R11 delayed word", 32'(rd_data), 32'(pat(n, s, r)));
          end else begin
            chk("R5 R2 R11 word", 32'(rd_data), 32'(pat(n, s, r)));
          end
          last = pat(n, s, r);
          if (n == 5) begin
            held = rd_data;
            rblk = 1'b1; ren = 1'b1;
            repeat (4) @(negedge rclk);
            chk("R3 read output held", 32'(rd_data), 32'(held));
            ren = 1'b0; rblk = 1'b0;
          end
        end
        wait_both(8);
        chk("R8 empty after drain", 32'(rd_empty), 1);
        chk("R9 aempty after drain", 32'(rd_aempty), 1);
        chk("R1 full cleared", 32'(wr_full), 0);

        // R8 refused read
        @(negedge rclk); ren = 1'b1;
        @(negedge rclk);
        chk("R8 underflow pulse", 32'(rd_udf), 1);
        ren = 1'b0;
        @(negedge rclk);
        chk("R8 underflow one cycle", 32'(rd_udf), 0);
        chk("R8 data unchanged", 32'(rd_data), 32'(last));
        rblk = 1'b1;
      end
    end
    done = 1;
    finish_run();
  end
endmodule